// File: doc/BRIEF.md
# Register-Controlled Open-Collector Parallel Bus Port

This block lets a CPU drive and sense a parallel, active-low, open-collector bus through a small bank of byte-wide registers. The bus has eight data lines, a parity line and nine control lines (reset, busy, select, request, acknowledge, attention, message, command/data and direction). Each pin is modelled as a pull-low enable output together with the sensed pin level, so the wired-AND of several drivers can be resolved outside the block. A 1 in a register pulls the matching pin low. On reads, an asserted (low) line returns 1.

The port works in one of two roles, chosen by a mode bit. In the responder role, the four phase lines can be driven and acknowledge and attention are inputs only. In the requester role, it is the other way round, and the data lines are only driven when the sensed phase matches the programmed phase and the direction line is not asserted. A bus reset, from any source including the block itself, clears every register. An optional busy monitor turns all drivers off when the busy line drops. With capture enabled, the data lines are stored on a handshake edge.

Top module: `ocbus_port`

## Requirements
- R1: After the synchronous reset `rst`, `data_oe` and `ctl_oe` are zero, and offsets 0 to 4 and 6 read 0. Offset 5 reads 0x08, because the all-zero phase bits match the idle bus.
- R2: A write to offset 0 always stores the byte, even when it is not driven. Reading offset 0 returns the inverted level of the data lines, whoever pulls them low. Offset 1 reads back bits 7 and 4..0 as written, with bits 6 and 5 reading 0. Offset 2 reads back all eight bits. Offset 3 reads back bits 3..0, with bits 7..4 reading 0.
- R3: `data_oe` equals the offset 0 byte only while offset 1 bit 0 is 1. Otherwise it is zero. In responder role (offset 2 bit 6 = 1) no other condition applies.
- R4: The `ctl_oe`/`ctl_in` bit positions are: 0 direction, 1 command/data, 2 message, 3 request, 4 select, 5 busy, 6 acknowledge, 7 attention, 8 reset.
  - Offset 1 bit 7 drives reset, bit 3 drives busy and bit 2 drives select, in both roles.
  - Offset 3 bits 3..0 drive request, message, command/data and direction, in responder role only.
  - Offset 1 bit 4 drives acknowledge and bit 1 drives attention, in requester role only.
- R5: In requester role, the data lines are driven only when two conditions hold: the sensed direction line is deasserted, and the sensed message, command/data and direction lines equal offset 3 bits 2, 1 and 0. Offset 5 bit 3 reads 1 exactly when that three-line equality holds in requester role. It reads 0 in responder role.
- R6: Offset 4 reads the sensed lines as bits 7..0: reset, busy, request, message, command/data, direction, select, parity. Offset 5 bit 1 reads sensed attention and bit 0 reads sensed acknowledge.
- R7: When the reset line is sensed asserted, including when the block drives it itself, all registers clear at the next clock edge. A write in that cycle is discarded.
- R8: While offset 2 bit 2 (busy monitor) is 1 and the busy line is not asserted, the error flag (offset 5 bit 2) sets at the next edge.
  - While the flag is set, every driver is off.
  - The flag clears one edge after the monitor bit has been written to 0.
  - No error arises while busy stays asserted.
- R9: With offset 2 bit 1 (capture) set, offset 6 stores the sensed data lines when a rising acknowledge is seen in responder role, or a rising request in requester role. With the capture bit clear, offset 6 keeps its value.
- R10: Writes to offsets 4 to 7 change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register offset for read and write |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte for `addr` (combinational) |
| data_oe | output | 8 | Pull-low enables for the data lines |
| data_in | input | 8 | Sensed data line levels (1 = high) |
| par_in | input | 1 | Sensed parity line level |
| ctl_oe | output | 9 | Pull-low enables for the control lines |
| ctl_in | input | 9 | Sensed control line levels |

## Verification
A register write takes effect at the rising edge where `wr_en` is sampled. The pin enables and read data are combinational from registers and sensed levels, so they are correct in the low half of the following cycle. The busy error, the bus-reset clear and the data capture each need one further edge after their cause is on the pins. The self-clear after the block drives reset therefore lands one edge after the write that drives it. The bench changes inputs only at falling edges and samples shortly after them. A behavioural model predicts the enables and the read byte, and these are compared in every cycle. Directed checks sit in the exact cycle before and after each delayed effect, so that an extra or missing register stage shows up.

// File: rtl/ocbus_pkg.sv
package ocbus_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned CTL_W  = 9;

   // control line positions in ctl_oe / ctl_in
   localparam int unsigned CI_IO  = 0;
   localparam int unsigned CI_CD  = 1;
   localparam int unsigned CI_MSG = 2;
   localparam int unsigned CI_REQ = 3;
   localparam int unsigned CI_SEL = 4;
   localparam int unsigned CI_BSY = 5;
   localparam int unsigned CI_ACK = 6;
   localparam int unsigned CI_ATN = 7;
   localparam int unsigned CI_RST = 8;

   // command register fields
   localparam int unsigned CB_RST  = 7;
   localparam int unsigned CB_ACK  = 4;
   localparam int unsigned CB_BSY  = 3;
   localparam int unsigned CB_SEL  = 2;
   localparam int unsigned CB_ATN  = 1;
   localparam int unsigned CB_DATA = 0;

   // mode register fields
   localparam int unsigned MB_TGT  = 6;
   localparam int unsigned MB_MONB = 2;
   localparam int unsigned MB_CAPT = 1;

   typedef enum logic [2:0] {
      RA_DATA  = 3'd0,
      RA_CMD   = 3'd1,
      RA_MODE  = 3'd2,
      RA_PHASE = 3'd3,
      RA_SENSE = 3'd4,
      RA_FLAGS = 3'd5,
      RA_CAPT  = 3'd6,
      RA_SPARE = 3'd7
   } reg_addr_e;
endpackage

// File: rtl/ocbus_sense.sv
module ocbus_sense #(
   parameter int unsigned STAGES = 0,
   parameter int unsigned W      = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] pin_lvl,
   output logic [W-1:0] asserted
);
   generate
      if (STAGES == 0) begin : g_direct
         logic unused_clkrst;
         assign unused_clkrst = clk ^ rst;
         assign asserted = ~pin_lvl;
      end else begin : g_sync
         logic [W-1:0] pipe [STAGES];
         always_ff @(posedge clk) begin
            if (rst) begin
               for (int i = 0; i < int'(STAGES); i++) pipe[i] <= '1;
            end else begin
               pipe[0] <= pin_lvl;
               for (int i = 1; i < int'(STAGES); i++) pipe[i] <= pipe[i-1];
            end
         end
         assign asserted = ~pipe[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/ocbus_regs.sv
module ocbus_regs
   import ocbus_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  reg_addr_e         waddr,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              bus_rst,
   input  logic              bus_bsy,
   input  logic              bus_ack,
   input  logic              bus_req,
   input  logic [BYTE_W-1:0] bus_data,
   output logic [BYTE_W-1:0] data_q,
   output logic [BYTE_W-1:0] cmd_q,
   output logic [BYTE_W-1:0] mode_q,
   output logic [3:0]        phase_q,
   output logic              berr_q,
   output logic [BYTE_W-1:0] capt_q
);
   logic wipe;
   logic ack_d, req_d;
   logic hs_rise;

   assign wipe    = rst | bus_rst;
   assign hs_rise = mode_q[MB_TGT] ? (bus_ack & ~ack_d) : (bus_req & ~req_d);

   always_ff @(posedge clk) begin
      if (wipe) begin
         data_q  <= '0;
         cmd_q   <= '0;
         mode_q  <= '0;
         phase_q <= '0;
         berr_q  <= 1'b0;
         capt_q  <= '0;
         ack_d   <= 1'b0;
         req_d   <= 1'b0;
      end else begin
         ack_d <= bus_ack;
         req_d <= bus_req;
         if (wr_en) begin
            case (waddr)
               RA_DATA:  data_q  <= wdata;
               RA_CMD:   cmd_q   <= {wdata[CB_RST], 2'b00, wdata[4:0]};
               RA_MODE:  mode_q  <= wdata;
               RA_PHASE: phase_q <= wdata[3:0];
               default:  ;
            endcase
         end
         if (!mode_q[MB_MONB])      berr_q <= 1'b0;
         else if (!bus_bsy)         berr_q <= 1'b1;
         if (mode_q[MB_CAPT] && hs_rise) capt_q <= bus_data;
      end
   end
endmodule

// File: rtl/ocbus_drive.sv
module ocbus_drive
   import ocbus_pkg::*;
(
   input  logic              enable,
   input  logic              tgt,
   input  logic [BYTE_W-1:0] cmd_q,
   input  logic [3:0]        phase_q,
   input  logic [BYTE_W-1:0] data_q,
   input  logic              s_msg,
   input  logic              s_cd,
   input  logic              s_io,
   output logic              phase_ok,
   output logic [BYTE_W-1:0] data_oe,
   output logic [CTL_W-1:0]  ctl_oe
);
   logic data_gate;
   logic unused_cmd;

   assign unused_cmd = ^cmd_q[6:5];
   assign phase_ok   = (s_msg == phase_q[2]) && (s_cd == phase_q[1]) && (s_io == phase_q[0]);
   assign data_gate  = enable && cmd_q[CB_DATA] && (tgt || (phase_ok && !s_io));
   assign data_oe    = data_gate ? data_q : '0;

   always_comb begin
      ctl_oe = '0;
      if (enable) begin
         ctl_oe[CI_RST] = cmd_q[CB_RST];
         ctl_oe[CI_BSY] = cmd_q[CB_BSY];
         ctl_oe[CI_SEL] = cmd_q[CB_SEL];
         if (tgt) begin
            ctl_oe[CI_REQ] = phase_q[3];
            ctl_oe[CI_MSG] = phase_q[2];
            ctl_oe[CI_CD]  = phase_q[1];
            ctl_oe[CI_IO]  = phase_q[0];
         end else begin
            ctl_oe[CI_ACK] = cmd_q[CB_ACK];
            ctl_oe[CI_ATN] = cmd_q[CB_ATN];
         end
      end
   end
endmodule

// File: rtl/ocbus_port.sv
module ocbus_port
   import ocbus_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [2:0]        addr,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rdata,
   output logic [BYTE_W-1:0] data_oe,
   input  logic [BYTE_W-1:0] data_in,
   input  logic              par_in,
   output logic [CTL_W-1:0]  ctl_oe,
   input  logic [CTL_W-1:0]  ctl_in
);
   localparam int unsigned SENSE_W = BYTE_W + CTL_W + 1;

   generate
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("ocbus_port: SYNC_STAGES must be 0 to 4");
      end
   endgenerate

   logic [SENSE_W-1:0] s_all;
   logic [BYTE_W-1:0]  s_data;
   logic [CTL_W-1:0]   s_ctl;
   logic               s_par;
   logic [BYTE_W-1:0]  data_q, cmd_q, mode_q, capt_q;
   logic [3:0]         phase_q;
   logic               berr_q, phase_ok, is_tgt, mon_bsy;
   reg_addr_e          ra;

   assign ra      = reg_addr_e'(addr);
   assign is_tgt  = mode_q[MB_TGT];
   assign mon_bsy = mode_q[MB_MONB];

   ocbus_sense #(.STAGES(SYNC_STAGES), .W(SENSE_W)) u_sense (
      .clk      (clk),
      .rst      (rst),
      .pin_lvl  ({par_in, ctl_in, data_in}),
      .asserted (s_all)
   );
   assign s_data = s_all[BYTE_W-1:0];
   assign s_ctl  = s_all[BYTE_W +: CTL_W];
   assign s_par  = s_all[SENSE_W-1];

   ocbus_regs u_regs (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_en),
      .waddr    (ra),
      .wdata    (wdata),
      .bus_rst  (s_ctl[CI_RST]),
      .bus_bsy  (s_ctl[CI_BSY]),
      .bus_ack  (s_ctl[CI_ACK]),
      .bus_req  (s_ctl[CI_REQ]),
      .bus_data (s_data),
      .data_q   (data_q),
      .cmd_q    (cmd_q),
      .mode_q   (mode_q),
      .phase_q  (phase_q),
      .berr_q   (berr_q),
      .capt_q   (capt_q)
   );

   ocbus_drive u_drive (
      .enable   (~berr_q),
      .tgt      (is_tgt),
      .cmd_q    (cmd_q),
      .phase_q  (phase_q),
      .data_q   (data_q),
      .s_msg    (s_ctl[CI_MSG]),
      .s_cd     (s_ctl[CI_CD]),
      .s_io     (s_ctl[CI_IO]),
      .phase_ok (phase_ok),
      .data_oe  (data_oe),
      .ctl_oe   (ctl_oe)
   );

   always_comb begin
      case (ra)
         RA_DATA:  rdata = s_data;
         RA_CMD:   rdata = cmd_q;
         RA_MODE:  rdata = mode_q;
         RA_PHASE: rdata = {4'b0000, phase_q};
         RA_SENSE: rdata = {s_ctl[CI_RST], s_ctl[CI_BSY], s_ctl[CI_REQ], s_ctl[CI_MSG],
                            s_ctl[CI_CD], s_ctl[CI_IO], s_ctl[CI_SEL], s_par};
         RA_FLAGS: rdata = {4'b0000, phase_ok & ~is_tgt, berr_q, s_ctl[CI_ATN], s_ctl[CI_ACK]};
         RA_CAPT:  rdata = capt_q;
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/ocbus_port_chk.sv
module ocbus_port_chk (
   input logic       clk,
   input logic       rst,
   input logic       tgt,
   input logic       mon,
   input logic       berr,
   input logic       io_act,
   input logic       bsy_act,
   input logic       rst_act,
   input logic [7:0] data_oe,
   input logic [8:0] ctl_oe
);
   assert_tgt_no_ack_R4: assert property (@(posedge clk) disable iff (rst)
      tgt |-> (!ctl_oe[6] && !ctl_oe[7]));

   assert_init_no_phase_R4: assert property (@(posedge clk) disable iff (rst)
      !tgt |-> (ctl_oe[3:0] == 4'h0));

   assert_init_dir_gate_R5: assert property (@(posedge clk) disable iff (rst)
      (!tgt && data_oe != 8'h00) |-> !io_act);

   assert_berr_quiet_R8: assert property (@(posedge clk) disable iff (rst)
      berr |-> (data_oe == 8'h00 && ctl_oe == 9'h000));

   assert_berr_set_R8: assert property (@(posedge clk) disable iff (rst)
      (mon && !bsy_act && !rst_act) |=> berr);

   assert_bus_wipe_R7: assert property (@(posedge clk) disable iff (rst)
      rst_act |=> (ctl_oe == 9'h000 && data_oe == 8'h00 && !berr));
endmodule

bind ocbus_port ocbus_port_chk u_chk (
   .clk     (clk),
   .rst     (rst),
   .tgt     (is_tgt),
   .mon     (mon_bsy),
   .berr    (berr_q),
   .io_act  (s_ctl[0]),
   .bsy_act (s_ctl[5]),
   .rst_act (s_ctl[8]),
   .data_oe (data_oe),
   .ctl_oe  (ctl_oe)
);

// File: tb/ocbus_port_test.sv
module ocbus_port_test;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       wr_en = 1'b0;
   logic [2:0] addr = 3'd0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata, data_oe, data_in;
   logic [8:0] ctl_oe, ctl_in;
   logic       par_in;
   logic [7:0] ext_d = 8'h00;
   logic [8:0] ext_c = 9'h000;
   logic       par_low = 1'b0;
   int         n_chk = 0;
   int         n_err = 0;
   bit         done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign data_in = ~(data_oe | ext_d);
   assign ctl_in  = ~(ctl_oe | ext_c);
   assign par_in  = ~par_low;

   ocbus_port uut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .data_oe(data_oe), .data_in(data_in), .par_in(par_in),
      .ctl_oe(ctl_oe), .ctl_in(ctl_in)
   );

   // ---------------- behavioural reference model ----------------
   bit [7:0] m_data, m_cmd, m_mode, m_capt;
   bit [3:0] m_phase;
   bit       m_berr, m_ack_d, m_req_d;
   bit [7:0] p_doe, p_dact, p_rd;
   bit [8:0] p_coe, p_cact;
   bit       p_match;

   always @* begin
      bit tgt;
      tgt   = m_mode[6];
      p_coe = 9'h000;
      if (!m_berr) begin
         p_coe[8] = m_cmd[7];
         p_coe[5] = m_cmd[3];
         p_coe[4] = m_cmd[2];
         if (tgt) p_coe[3:0] = m_phase;
         else begin
            p_coe[6] = m_cmd[4];
            p_coe[7] = m_cmd[1];
         end
      end
      p_cact  = p_coe | ext_c;
      p_match = (p_cact[2:0] == m_phase[2:0]);
      if (!m_berr && m_cmd[0] && (tgt || (p_match && !p_cact[0]))) p_doe = m_data;
      else p_doe = 8'h00;
      p_dact = p_doe | ext_d;
      case (addr)
         3'd0: p_rd = p_dact;
         3'd1: p_rd = m_cmd;
         3'd2: p_rd = m_mode;
         3'd3: p_rd = {4'h0, m_phase};
         3'd4: p_rd = {p_cact[8], p_cact[5], p_cact[3], p_cact[2], p_cact[1], p_cact[0], p_cact[4], par_low};
         3'd5: p_rd = {4'h0, p_match && !tgt, m_berr, p_cact[7], p_cact[6]};
         3'd6: p_rd = m_capt;
         default: p_rd = 8'h00;
      endcase
   end

   always @(posedge clk) begin
      if (rst || p_cact[8]) begin
         m_data <= 0; m_cmd <= 0; m_mode <= 0; m_phase <= 0;
         m_berr <= 0; m_capt <= 0; m_ack_d <= 0; m_req_d <= 0;
      end else begin
         m_ack_d <= p_cact[6];
         m_req_d <= p_cact[3];
         if (wr_en) begin
            if (addr == 3'd0) m_data <= wdata;
            if (addr == 3'd1) m_cmd <= wdata & 8'h9F;
            if (addr == 3'd2) m_mode <= wdata;
            if (addr == 3'd3) m_phase <= wdata[3:0];
         end
         if (m_mode[2] == 1'b0) m_berr <= 1'b0;
         else if (p_cact[5] == 1'b0) m_berr <= 1'b1;
         if (m_mode[1]) begin
            if (m_mode[6] && p_cact[6] && !m_ack_d) m_capt <= p_dact;
            if (!m_mode[6] && p_cact[3] && !m_req_d) m_capt <= p_dact;
         end
      end
   end

   // ---------------- checking ----------------
   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!rst && !done) begin
         #3;
         chk("R3/R5 model data_oe", {8'h00, data_oe}, {8'h00, p_doe});
         chk("R4/R8 model ctl_oe", {7'h00, ctl_oe}, {7'h00, p_coe});
         chk("R2/R6 model rdata", {8'h00, rdata}, {8'h00, p_rd});
      end
   end

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
      addr = a;
      #1;
      chk(tag, {8'h00, rdata}, {8'h00, exp});
   endtask

   task automatic pins(input logic [7:0] d, input logic [8:0] c, input string tag);
      #1;
      chk(tag, {8'h00, data_oe}, {8'h00, d});
      chk(tag, {7'h00, ctl_oe}, {7'h00, c});
   endtask

   initial begin
      repeat (CLK_PERIOD * 20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst = 1'b0;
      // R1 reset state
      pins(8'h00, 9'h000, "R1 drivers idle");
      rd(3'd0, 8'h00, "R1 data"); rd(3'd1, 8'h00, "R1 cmd"); tick();
      rd(3'd2, 8'h00, "R1 mode"); rd(3'd3, 8'h00, "R1 phase"); tick();
      rd(3'd4, 8'h00, "R1 sense"); rd(3'd5, 8'h08, "R1 flags"); rd(3'd6, 8'h00, "R1 capt"); tick();
      // R2 stored but not driven
      wr(3'd0, 8'hA5);
      pins(8'h00, 9'h000, "R3 no assert bit");
      rd(3'd0, 8'h00, "R2 undriven read");
      ext_d = 8'h3C;
      rd(3'd0, 8'h3C, "R2 external pull");
      // requester role, phase matches idle bus
      wr(3'd1, 8'h5F);
      pins(8'hA5, 9'h0F0, "R3/R4 requester drive");
      rd(3'd1, 8'h1F, "R2 cmd readback");
      rd(3'd0, 8'hBD, "R2 wired-and read");
      ext_d = 8'h00;
      // R5 phase gating
      wr(3'd3, 8'h01);
      pins(8'h00, 9'h0F0, "R5 phase mismatch");
      rd(3'd5, 8'h03, "R5/R6 flags mismatch");
      ext_c[0] = 1'b1;
      pins(8'h00, 9'h0F0, "R5 direction asserted");
      rd(3'd5, 8'h0B, "R5 match flag");
      ext_c[0] = 1'b0;
      wr(3'd3, 8'h00);
      // R4 responder role
      wr(3'd2, 8'h40);
      pins(8'hA5, 9'h030, "R4 responder no ack/atn");
      wr(3'd3, 8'h0F);
      pins(8'hA5, 9'h03F, "R3/R4 responder phase drive");
      rd(3'd5, 8'h00, "R5 flag masked");
      rd(3'd3, 8'h0F, "R2 phase readback");
      ext_c[6] = 1'b1;
      rd(3'd5, 8'h01, "R6 ack sensed");
      rd(3'd4, 8'h7E, "R6 sense layout");
      par_low = 1'b1;
      tick();
      rd(3'd4, 8'h7F, "R6 parity bit");
      par_low = 1'b0; ext_c[6] = 1'b0;
      tick();
      // R9 capture
      wr(3'd2, 8'h42);
      ext_c[6] = 1'b1; tick(); ext_c[6] = 1'b0;
      rd(3'd6, 8'hA5, "R9 responder capture");
      wr(3'd2, 8'h40);
      wr(3'd0, 8'h11);
      ext_c[6] = 1'b1; tick(); ext_c[6] = 1'b0;
      rd(3'd6, 8'hA5, "R9 capture disabled");
      wr(3'd2, 8'h02);
      tick();
      ext_d = 8'h66; ext_c[3] = 1'b1; tick(); ext_c[3] = 1'b0; ext_d = 8'h00;
      rd(3'd6, 8'h66, "R9 requester capture");
      // R10 writes to read-only offsets
      wr(3'd4, 8'hFF); wr(3'd5, 8'hFF); wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
      rd(3'd1, 8'h1F, "R10 cmd kept"); rd(3'd2, 8'h02, "R10 mode kept"); tick();
      rd(3'd3, 8'h0F, "R10 phase kept"); rd(3'd6, 8'h66, "R10 capt kept"); tick();
      // R8 busy monitor
      wr(3'd1, 8'h01);
      wr(3'd2, 8'h44);
      pins(8'h11, 9'h00F, "R8 before error");
      rd(3'd5, 8'h00, "R8 flag not yet");
      tick();
      pins(8'h00, 9'h000, "R8 drivers off");
      rd(3'd5, 8'h04, "R8 error flag");
      wr(3'd2, 8'h40);
      pins(8'h00, 9'h000, "R8 still latched");
      tick();
      pins(8'h11, 9'h00F, "R8 released");
      rd(3'd5, 8'h00, "R8 flag cleared");
      wr(3'd1, 8'h09);
      wr(3'd2, 8'h44);
      tick(); tick();
      pins(8'h11, 9'h02F, "R8 busy held");
      rd(3'd5, 8'h00, "R8 no error with busy");
      wr(3'd2, 8'h40);
      // R7 bus reset
      ext_c[8] = 1'b1; tick(); ext_c[8] = 1'b0;
      rd(3'd1, 8'h00, "R7 external cmd"); rd(3'd2, 8'h00, "R7 external mode");
      rd(3'd3, 8'h00, "R7 external phase");
      pins(8'h00, 9'h000, "R7 external drivers");
      tick();
      wr(3'd3, 8'h05);
      wr(3'd1, 8'h80);
      pins(8'h00, 9'h100, "R7 own reset driven");
      tick();
      pins(8'h00, 9'h000, "R7 self clear");
      rd(3'd3, 8'h00, "R7 self clear phase");
      tick();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule